// File: doc/BRIEF.md
# Nested Priority Interrupt Arbiter

This block sits between a bank of 32 maskable interrupt request lines and a processor core. Each line has its own enable bit, pending bit and 2-bit urgency level, all reachable through a small register port. Every cycle the block looks for the most urgent enabled and pending line. It presents that line's index to the core only when the line may interrupt the work currently in progress. That is the case when no handler is running, or when the line is strictly more urgent than the running handler.

Once a winner is chosen, a fixed entry window of `ENTRY_CYC` cycles follows. During the window a strictly more urgent line that shows up late replaces the presented choice. After the window the choice is frozen and the core acknowledges it. On acknowledge the block clears the winner's pending bit and pushes its level onto a stack of active levels. An end-of-handler pulse pops the stack, which restores the level that was in force before that handler began. Handlers therefore nest up to one per urgency level.

Top module: `irq_nest_arb`

## Requirements
- R1: After reset, all enable bits, pending bits and levels read 0, `irq_valid` is 0 and `act_depth` is 0.
- R2: The register port works as follows, with writes taking effect at the clock edge where `reg_we` is 1 and reads returned combinationally on `reg_rdata`.
  - `reg_sel`=0 writes the whole enable mask and reads it back.
  - `reg_sel`=1 sets the pending bits that are 1 in `reg_wdata`.
  - `reg_sel`=2 clears the pending bits that are 1 in `reg_wdata`.
  - `reg_sel`=1 and `reg_sel`=2 both read back the pending mask.
  - `reg_sel`=3 writes or reads the level of channel `reg_idx` in bits [1:0].
- R3: A 1 on `irq_req[i]` at a clock edge sets pending bit i whether or not the channel is enabled. A pending but disabled channel is never presented.
- R4: Among enabled pending channels, level 0 is the most urgent. When levels are equal, the lowest channel index wins.
- R5: `irq_valid` rises one cycle after the edge at which a takeable candidate first exists. `irq_locked` stays 0 for `ENTRY_CYC` cycles and then rises.
- R6: While `irq_valid` is 1 and `irq_locked` is 0, a candidate strictly more urgent than the presented one replaces `irq_vec`/`irq_prio`. An equally urgent candidate does not.
- R7: While `irq_locked` is 1, `irq_vec` stays fixed until acknowledge. `irq_ack` has no effect while `irq_locked` is 0.
- R8: `irq_ack` while `irq_locked` is 1 does the following at that edge:
  - clears the presented channel's pending bit;
  - sets `act_prio` to its level;
  - increments `act_depth`;
  - returns `irq_valid` to 0.
- R9: While a handler is active, a candidate is taken only when its level value is strictly below `act_prio`. Equal or less urgent requests stay pending.
- R10: `irq_eoi` pops the stack, so `act_prio` returns to the level that was active before the ending handler started. At depth 0, `irq_eoi` leaves the depth at 0.
- R11: When `irq_eoi` and an accepted `irq_ack` fall on the same edge, the acknowledge is applied and the end-of-handler is dropped.
- R12: A pending bit cleared by acknowledge can be set again by `irq_req` while its own handler is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_req | input | 32 | Request lines, one per channel |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select (enable, set, clear, level) |
| reg_idx | input | 5 | Channel index for level access |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| irq_ack | input | 1 | Core acknowledge of the presented vector |
| irq_eoi | input | 1 | End of the innermost handler |
| irq_valid | output | 1 | A vector is being presented |
| irq_locked | output | 1 | Entry window over, vector frozen |
| irq_vec | output | 5 | Presented channel index |
| irq_prio | output | 2 | Level of the presented channel |
| act_prio | output | 2 | Level of the innermost active handler (0 when none) |
| act_depth | output | 3 | Number of nested active handlers |

## Verification
The bound checker watches, on every cycle, several ordering rules:
- a frozen vector never moves before acknowledge;
- an accepted acknowledge pushes exactly the presented level;
- a replacement during the window is always strictly more urgent;
- a newly presented vector always beats the active level;
- acknowledge outside the lock and end-of-handler behave as stated.

Only the bench scenarios can show which channel wins for given enable and pending patterns, the exact cycle on which the window opens and locks, and the return to a saved level after nested handlers. The same holds for requests that stay pending because they are not urgent enough.

// File: rtl/irq_arb_pkg.sv
// Shared types and register select codes for the nested interrupt arbiter.
package irq_arb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ENTRY  = 2'd1,
        ST_COMMIT = 2'd2
    } arb_state_e;

    localparam logic [1:0] SEL_ENABLE = 2'd0;
    localparam logic [1:0] SEL_PSET   = 2'd1;
    localparam logic [1:0] SEL_PCLR   = 2'd2;
    localparam logic [1:0] SEL_LEVEL  = 2'd3;
endpackage

// File: rtl/irq_pend_bank.sv
// Per-channel enable, pending and level storage plus register readback.
// Assumes at most one channel is cleared by acknowledge per cycle; clear by
// acknowledge wins over a same-cycle set, hardware set wins over software clear.
module irq_pend_bank
    import irq_arb_pkg::*;
#(
    parameter int NUM_IRQ = 32,
    parameter int PRIO_W  = 2,
    localparam int IDX_W  = $clog2(NUM_IRQ)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_IRQ-1:0]        irq_req,
    input  logic                      reg_we,
    input  logic [1:0]                reg_sel,
    input  logic [IDX_W-1:0]          reg_idx,
    input  logic [NUM_IRQ-1:0]        reg_wdata,
    output logic [NUM_IRQ-1:0]        reg_rdata,
    input  logic                      ack_clr,
    input  logic [IDX_W-1:0]          ack_idx,
    output logic [NUM_IRQ-1:0]        en_q,
    output logic [NUM_IRQ-1:0]        pend_q,
    output logic [NUM_IRQ*PRIO_W-1:0] prio_flat
);
    logic [NUM_IRQ-1:0][PRIO_W-1:0] lvl_q;

    // Enable mask register, written as a whole word.
    always_ff @(posedge clk) begin
        if (!rst_n)
            en_q <= '0;
        else if (reg_we && reg_sel == SEL_ENABLE)
            en_q <= reg_wdata;
    end

    for (genvar g = 0; g < NUM_IRQ; g++) begin : g_chan
        logic sw_set, sw_clr, ack_hit;
        assign sw_set  = reg_we && reg_sel == SEL_PSET && reg_wdata[g];
        assign sw_clr  = reg_we && reg_sel == SEL_PCLR && reg_wdata[g];
        assign ack_hit = ack_clr && ack_idx == IDX_W'(g);

        // Pending bit of one channel: acknowledge clear, then set, then soft clear.
        always_ff @(posedge clk) begin
            if (!rst_n)
                pend_q[g] <= 1'b0;
            else if (ack_hit)
                pend_q[g] <= 1'b0;
            else if (irq_req[g] || sw_set)
                pend_q[g] <= 1'b1;
            else if (sw_clr)
                pend_q[g] <= 1'b0;
        end

        // Level field of one channel, written through the indexed select.
        always_ff @(posedge clk) begin
            if (!rst_n)
                lvl_q[g] <= '0;
            else if (reg_we && reg_sel == SEL_LEVEL && reg_idx == IDX_W'(g))
                lvl_q[g] <= reg_wdata[PRIO_W-1:0];
        end

        assign prio_flat[g*PRIO_W +: PRIO_W] = lvl_q[g];
    end

    // Readback multiplexer for the register port.
    always_comb begin
        reg_rdata = '0;
        unique case (reg_sel)
            SEL_ENABLE:          reg_rdata = en_q;
            SEL_PSET, SEL_PCLR:  reg_rdata = pend_q;
            default:             reg_rdata[PRIO_W-1:0] = lvl_q[reg_idx];
        endcase
    end
endmodule

// File: rtl/irq_pick.sv
// Finds the most urgent eligible channel: smallest level value, ties to the
// lowest index. Purely combinational.
module irq_pick #(
    parameter int NUM_IRQ = 32,
    parameter int PRIO_W  = 2,
    localparam int IDX_W  = $clog2(NUM_IRQ)
) (
    input  logic [NUM_IRQ-1:0]        elig,
    input  logic [NUM_IRQ*PRIO_W-1:0] prio_flat,
    output logic                      cand_valid,
    output logic [IDX_W-1:0]          cand_idx,
    output logic [PRIO_W-1:0]         cand_prio
);
    // Linear scan in ascending index; strict compare keeps the lowest index on ties.
    always_comb begin
        cand_valid = 1'b0;
        cand_idx   = '0;
        cand_prio  = '1;
        for (int i = 0; i < NUM_IRQ; i++) begin
            if (elig[i] && (!cand_valid || prio_flat[i*PRIO_W +: PRIO_W] < cand_prio)) begin
                cand_valid = 1'b1;
                cand_idx   = IDX_W'(i);
                cand_prio  = prio_flat[i*PRIO_W +: PRIO_W];
            end
        end
    end
endmodule

// File: rtl/irq_prio_stack.sv
// Stack of active handler levels. Push when full and pop when empty are ignored;
// a same-cycle pop is dropped in favour of the push.
module irq_prio_stack #(
    parameter int PRIO_W = 2,
    parameter int DEPTH  = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [PRIO_W-1:0] push_prio,
    input  logic              pop,
    output logic [PRIO_W-1:0] top_prio,
    output logic [CNT_W-1:0]  depth,
    output logic              nonempty
);
    logic [DEPTH-1:0][PRIO_W-1:0] stk_q;
    logic                         full;

    assign full     = depth == CNT_W'(DEPTH);
    assign nonempty = depth != '0;

    // Depth counter and slot writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            depth <= '0;
            stk_q <= '0;
        end else if (push && !full) begin
            stk_q[PTR_W'(depth)] <= push_prio;
            depth                <= depth + 1'b1;
        end else if (pop && !push && nonempty) begin
            depth <= depth - 1'b1;
        end
    end

    // Innermost level, reported as 0 when nothing is active.
    always_comb begin
        top_prio = '0;
        if (nonempty)
            top_prio = stk_q[PTR_W'(depth - 1'b1)];
    end
endmodule

// File: rtl/irq_nest_arb.sv
// Top of the nested interrupt arbiter. Picks a winner, runs the entry window
// (late-arrival replacement allowed), freezes the vector, and on acknowledge
// pushes the winner's level. Assumes ENTRY_CYC >= 1 and one level per nest slot.
module irq_nest_arb
    import irq_arb_pkg::*;
#(
    parameter int NUM_IRQ   = 32,
    parameter int PRIO_W    = 2,
    parameter int ENTRY_CYC = 3,
    localparam int IDX_W    = $clog2(NUM_IRQ),
    localparam int NEST     = 1 << PRIO_W,
    localparam int DEP_W    = $clog2(NEST + 1),
    localparam int CNT_W    = $clog2(ENTRY_CYC + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IRQ-1:0] irq_req,
    input  logic               reg_we,
    input  logic [1:0]         reg_sel,
    input  logic [IDX_W-1:0]   reg_idx,
    input  logic [NUM_IRQ-1:0] reg_wdata,
    output logic [NUM_IRQ-1:0] reg_rdata,
    input  logic               irq_ack,
    input  logic               irq_eoi,
    output logic               irq_valid,
    output logic               irq_locked,
    output logic [IDX_W-1:0]   irq_vec,
    output logic [PRIO_W-1:0]  irq_prio,
    output logic [PRIO_W-1:0]  act_prio,
    output logic [DEP_W-1:0]   act_depth
);
    arb_state_e               st_q;
    logic [CNT_W-1:0]         win_cnt_q;
    logic [IDX_W-1:0]         sel_idx_q;
    logic [PRIO_W-1:0]        sel_prio_q;
    logic [NUM_IRQ-1:0]       en_q, pend_q;
    logic [NUM_IRQ*PRIO_W-1:0] prio_flat;
    logic                     cand_valid;
    logic [IDX_W-1:0]         cand_idx;
    logic [PRIO_W-1:0]        cand_prio;
    logic                     stk_nonempty;
    logic                     can_take, late_better, ack_take;

    irq_pend_bank #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) bank_i (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req),
        .reg_we(reg_we), .reg_sel(reg_sel), .reg_idx(reg_idx),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ack_clr(ack_take), .ack_idx(sel_idx_q),
        .en_q(en_q), .pend_q(pend_q), .prio_flat(prio_flat)
    );

    irq_pick #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) pick_i (
        .elig(en_q & pend_q), .prio_flat(prio_flat),
        .cand_valid(cand_valid), .cand_idx(cand_idx), .cand_prio(cand_prio)
    );

    irq_prio_stack #(.PRIO_W(PRIO_W), .DEPTH(NEST)) stack_i (
        .clk(clk), .rst_n(rst_n),
        .push(ack_take), .push_prio(sel_prio_q), .pop(irq_eoi),
        .top_prio(act_prio), .depth(act_depth), .nonempty(stk_nonempty)
    );

    assign can_take    = cand_valid && (!stk_nonempty || cand_prio < act_prio);
    assign late_better = cand_valid && cand_prio < sel_prio_q;
    assign ack_take    = st_q == ST_COMMIT && irq_ack;

    // Entry sequencer: idle -> window (replaceable) -> committed -> idle on acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= ST_IDLE;
            win_cnt_q  <= '0;
            sel_idx_q  <= '0;
            sel_prio_q <= '0;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (can_take) begin
                        st_q       <= ST_ENTRY;
                        win_cnt_q  <= CNT_W'(ENTRY_CYC - 1);
                        sel_idx_q  <= cand_idx;
                        sel_prio_q <= cand_prio;
                    end
                end
                ST_ENTRY: begin
                    if (late_better) begin
                        sel_idx_q  <= cand_idx;
                        sel_prio_q <= cand_prio;
                    end
                    if (win_cnt_q == '0)
                        st_q <= ST_COMMIT;
                    else
                        win_cnt_q <= win_cnt_q - 1'b1;
                end
                ST_COMMIT: begin
                    if (irq_ack)
                        st_q <= ST_IDLE;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign irq_valid  = st_q != ST_IDLE;
    assign irq_locked = st_q == ST_COMMIT;
    assign irq_vec    = sel_idx_q;
    assign irq_prio   = sel_prio_q;
endmodule

// File: rtl/irq_nest_arb_chk.sv
// Cycle-by-cycle ordering rules of the arbiter's core-side interface.
module irq_nest_arb_chk #(
    parameter int IDX_W  = 5,
    parameter int PRIO_W = 2,
    parameter int DEP_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              irq_ack,
    input logic              irq_eoi,
    input logic              irq_valid,
    input logic              irq_locked,
    input logic [IDX_W-1:0]  irq_vec,
    input logic [PRIO_W-1:0] irq_prio,
    input logic [PRIO_W-1:0] act_prio,
    input logic [DEP_W-1:0]  act_depth
);
    p_frozen_vec_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_locked && !irq_ack |=> irq_valid && $stable(irq_vec));

    p_ack_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid && !irq_locked && irq_ack && !irq_eoi |=> irq_valid && $stable(act_depth));

    p_ack_push_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_locked && irq_ack |=> !irq_valid && act_prio == $past(irq_prio)
                                  && act_depth == $past(act_depth) + 1'b1);

    p_late_higher_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid && $past(irq_valid) && irq_vec != $past(irq_vec)
        |-> irq_prio < $past(irq_prio) && !$past(irq_locked));

    p_strict_preempt_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_valid) && $past(act_depth) != '0 |-> irq_prio < $past(act_prio));

    p_eoi_pop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_eoi && !(irq_locked && irq_ack) && act_depth != '0
        |=> act_depth == $past(act_depth) - 1'b1);

    p_eoi_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_eoi && !(irq_locked && irq_ack) && act_depth == '0 |=> act_depth == '0);
endmodule

bind irq_nest_arb irq_nest_arb_chk #(.IDX_W(IDX_W), .PRIO_W(PRIO_W), .DEP_W(DEP_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .irq_ack(irq_ack), .irq_eoi(irq_eoi),
    .irq_valid(irq_valid), .irq_locked(irq_locked), .irq_vec(irq_vec),
    .irq_prio(irq_prio), .act_prio(act_prio), .act_depth(act_depth)
);

// File: tb/irq_nest_arb_tb_top.sv
// Self-checking bench: vector table for winner selection, then directed tests.
module irq_nest_arb_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] irq_req = '0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_sel = '0;
    logic [4:0]  reg_idx = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_ack = 1'b0, irq_eoi = 1'b0;
    logic        irq_valid, irq_locked;
    logic [4:0]  irq_vec;
    logic [1:0]  irq_prio, act_prio;
    logic [2:0]  act_depth;
    int          n_chk = 0, n_fail = 0;
    logic [31:0] rd;

    always #4 clk = ~clk;

    irq_nest_arb dut_i (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .reg_we(reg_we),
        .reg_sel(reg_sel), .reg_idx(reg_idx), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_ack(irq_ack), .irq_eoi(irq_eoi),
        .irq_valid(irq_valid), .irq_locked(irq_locked), .irq_vec(irq_vec),
        .irq_prio(irq_prio), .act_prio(act_prio), .act_depth(act_depth)
    );

    // {enable, pending, expected vector}; channel i has level 3 - (i % 4).
    localparam logic [95:0] SEL_TAB [6] = '{
        {32'hFFFF_FFFF, 32'h0000_0001, 32'd0},
        {32'hFFFF_FFFF, 32'h0000_0006, 32'd2},
        {32'hFFFF_FFFF, 32'h8000_0001, 32'd31},
        {32'hFFFF_FFFF, 32'h0000_0088, 32'd3},
        {32'hFFFF_FFF7, 32'h0000_0088, 32'd7},
        {32'h0000_FFFF, 32'h0001_0010, 32'd4}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic reg_write(input logic [1:0] sel, input logic [4:0] idx, input logic [31:0] d);
        reg_we = 1'b1; reg_sel = sel; reg_idx = idx; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] sel, input logic [4:0] idx, output logic [31:0] d);
        reg_sel = sel; reg_idx = idx;
        #1 d = reg_rdata;
    endtask

    task automatic wait_locked(input string req);
        int k = 0;
        while (!irq_locked && k < 20) begin
            @(negedge clk);
            k++;
        end
        check(req, irq_locked, 1'b1);
    endtask

    task automatic pulse_ack;
        irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
    endtask

    task automatic pulse_eoi;
        irq_eoi = 1'b1; @(negedge clk); irq_eoi = 1'b0;
    endtask

    // Acknowledge the presented vector, drop all pending, end the handler.
    task automatic retire;
        pulse_ack;
        reg_write(2'd2, 5'd0, 32'hFFFF_FFFF);
        pulse_eoi;
    endtask

    initial begin
        #(8 * 100000);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        // R1 reset state
        check("R1 valid", irq_valid, 0);
        check("R1 depth", act_depth, 0);
        reg_read(2'd0, 5'd0, rd); check("R1 enable", rd, 0);
        reg_read(2'd1, 5'd0, rd); check("R1 pending", rd, 0);
        reg_read(2'd3, 5'd5, rd); check("R1 level", rd, 0);

        // R2 register port: enable readback, level per channel
        @(negedge clk);
        reg_write(2'd0, 5'd0, 32'hA5A5_0F0F);
        reg_read(2'd0, 5'd0, rd); check("R2 enable rb", rd, 32'hA5A5_0F0F);
        for (int i = 0; i < 32; i++) reg_write(2'd3, 5'(i), 32'(3 - (i % 4)));
        reg_read(2'd3, 5'd6, rd); check("R2 level rb", rd, 1);
        reg_write(2'd0, 5'd0, 32'h0);
        reg_write(2'd1, 5'd0, 32'h0000_F000);
        reg_write(2'd2, 5'd0, 32'h0000_3000);
        reg_read(2'd2, 5'd0, rd); check("R2 pend set/clr", rd, 32'h0000_C000);
        reg_write(2'd2, 5'd0, 32'hFFFF_FFFF);

        // R4 winner selection table
        for (int k = 0; k < 6; k++) begin
            reg_write(2'd0, 5'd0, SEL_TAB[k][95:64]);
            reg_write(2'd1, 5'd0, SEL_TAB[k][63:32]);
            wait_locked("R4 lock");
            check("R4 winner", irq_vec, SEL_TAB[k][31:0]);
            retire;
            step(1);
        end
        reg_write(2'd0, 5'd0, 32'hFFFF_FFFF);

        // R5 entry window timing
        reg_write(2'd1, 5'd0, 32'h1);
        check("R5 not yet valid", irq_valid, 0);
        step(1); check("R5 valid", irq_valid, 1); check("R5 open1", irq_locked, 0);
        step(1); check("R5 open2", irq_locked, 0);
        step(1); check("R5 open3", irq_locked, 0);
        step(1); check("R5 locked", irq_locked, 1);
        // R7 higher request after lock does not replace
        reg_write(2'd1, 5'd0, 32'h8);
        step(2); check("R7 frozen vec", irq_vec, 0);
        // R8 acknowledge effects
        pulse_ack;
        check("R8 valid drop", irq_valid, 0);
        check("R8 depth", act_depth, 1);
        check("R8 act prio", act_prio, 3);
        reg_read(2'd1, 5'd0, rd); check("R8 pend cleared", rd, 32'h8);
        // R9 higher level preempts
        wait_locked("R9 preempt lock");
        check("R9 preempt vec", irq_vec, 3);
        pulse_ack;
        check("R9 depth2", act_depth, 2);
        check("R9 act prio0", act_prio, 0);
        // R12 re-request of a running channel
        irq_req[0] = 1'b1; step(1); irq_req[0] = 1'b0;
        reg_read(2'd1, 5'd0, rd); check("R12 re-pend", rd[0], 1);
        // R10 restore saved level
        pulse_eoi;
        check("R10 pop depth", act_depth, 1);
        check("R10 restored", act_prio, 3);
        // R9 equal level stays pending
        step(8); check("R9 equal blocked", irq_valid, 0);
        pulse_eoi;
        check("R10 depth0", act_depth, 0);
        wait_locked("R9 taken after eoi");
        check("R9 taken vec", irq_vec, 0);
        retire;

        // R6 late arrival of a more urgent channel
        reg_write(2'd1, 5'd0, 32'h1);
        step(1); check("R6 first vec", irq_vec, 0);
        reg_write(2'd1, 5'd0, 32'h4);
        step(1);
        check("R6 replaced", irq_vec, 2);
        check("R6 still open", irq_locked, 0);
        wait_locked("R6 lock");
        check("R6 final prio", irq_prio, 1);
        retire;
        // R6 equal late arrival does not replace
        reg_write(2'd1, 5'd0, 32'h2);
        step(1);
        reg_write(2'd1, 5'd0, 32'h20);
        wait_locked("R6 eq lock");
        check("R6 equal kept", irq_vec, 1);
        retire;

        // R7 acknowledge inside window ignored
        reg_write(2'd1, 5'd0, 32'h1);
        step(1);
        pulse_ack;
        check("R7 ack ignored depth", act_depth, 0);
        check("R7 ack ignored valid", irq_valid, 1);
        wait_locked("R7 lock");
        retire;

        // R10 end-of-handler with nothing active
        pulse_eoi;
        check("R10 empty eoi", act_depth, 0);

        // R11 acknowledge and end-of-handler on one edge
        reg_write(2'd1, 5'd0, 32'h1);
        wait_locked("R11 lock1");
        pulse_ack;
        reg_write(2'd1, 5'd0, 32'h8);
        wait_locked("R11 lock2");
        irq_ack = 1'b1; irq_eoi = 1'b1;
        step(1);
        irq_ack = 1'b0; irq_eoi = 1'b0;
        check("R11 depth", act_depth, 2);
        check("R11 prio", act_prio, 0);
        reg_write(2'd2, 5'd0, 32'hFFFF_FFFF);
        pulse_eoi;
        pulse_eoi;
        check("R11 unwound", act_depth, 0);

        // R3 request on a disabled channel
        reg_write(2'd0, 5'd0, ~32'h200);
        irq_req[9] = 1'b1; step(1); irq_req[9] = 1'b0;
        step(5);
        check("R3 disabled not shown", irq_valid, 0);
        reg_read(2'd1, 5'd0, rd); check("R3 pend set", rd, 32'h200);
        reg_write(2'd0, 5'd0, 32'hFFFF_FFFF);
        wait_locked("R3 lock");
        check("R3 vec", irq_vec, 9);
        retire;
        reg_read(2'd1, 5'd0, rd); check("R2 all clear", rd, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule